// File: doc/BRIEF.md
# Tagged Byte Loader for a Packet Transmit Queue

This block is the write side of a transmit byte queue for a bit-oriented framing transmitter. Software writes payload bytes one at a time. Each accepted byte is stored together with two marker bits: one ends the packet and one aborts the frame. The serial transmitter reads these markers later to decide between closing the packet normally and sending an abort sequence.

Markers come from two places. The first is a pair of pending bits that software sets in a control write before the data byte. These bits clear themselves once a byte is accepted. The second is a down-counting length register. When it is loaded with the packet length, it marks the final byte on its own. In repeat mode it reloads itself after each packet, so a stream of equal-length packets needs no further control writes. The queue shows its head entry to the transmitter and reports full, empty and fill level. Writes that find the queue full are discarded and leave a sticky overflow flag.

Top module: `ptf_wr_front`

## Requirements
- R1: Each queue entry holds an 8-bit byte, an end-of-packet marker and an abort marker. Entries leave in the order they were accepted. The head entry is shown on `rd_data`, `rd_eop` and `rd_abort` whenever `empty` is 0.
- R2: A cycle with `ctl_wr` high loads the pending markers from `ctl_eop` and `ctl_abort`. The next accepted data write copies them into its entry.
- R3: An accepted data write clears both pending markers. If `ctl_wr` is high in the same cycle, the entry takes the old pending values and the newly written values remain pending.
- R4: A cycle with `cnt_wr` high loads the length register with `cnt_len`. Each accepted data write lowers a nonzero length by one. The write accepted while the length is 1 gets the end-of-packet marker. A length of 0 never adds a marker.
- R5: With `cnt_cycle` latched high at the last length load, the write marked by the length register reloads the loaded length. With it latched low, the length drops to 0 and later bytes carry no length marker.
- R6: If the abort marker is pending, the entry has abort 1 and end-of-packet 0, whatever the end-of-packet request. The length register still advances.
- R7: A data write made while `full` is 1 is discarded. It leaves the level, the pending markers and the length register unchanged, and it sets `overflow`, which stays 1 until reset.
- R8: `level` counts stored entries from 0 to 16. `full` is 1 at 16 and `empty` is 1 at 0. A `pop` while empty is ignored. A write and a pop in the same cycle on a queue that is neither empty nor full leave the level unchanged.
- R9: After reset the queue is empty, `level` is 0, `overflow` is 0, no marker is pending and the length register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Load the pending markers |
| ctl_eop | input | 1 | End-of-packet value for the pending marker |
| ctl_abort | input | 1 | Abort value for the pending marker |
| cnt_wr | input | 1 | Load the length register and the repeat mode |
| cnt_len | input | CNT_W | Packet length to load |
| cnt_cycle | input | 1 | Repeat mode value latched on `cnt_wr` |
| dat_wr | input | 1 | Write one data byte |
| dat_wdata | input | 8 | Data byte |
| pop | input | 1 | Transmitter removes the head entry |
| rd_data | output | 8 | Head entry byte |
| rd_eop | output | 1 | Head entry end-of-packet marker |
| rd_abort | output | 1 | Head entry abort marker |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |
| level | output | LVL_W | Number of stored entries |
| overflow | output | 1 | Sticky flag for a discarded write |

## Verification
If a pending marker fails to clear, or the length register is off by one, the fault appears as a wrong marker bit on an entry. That entry becomes visible at the head only after every earlier entry has been popped. For this reason the bench drains the queue and compares each head entry against a bench-side model. A wrong read or write pointer corrupts `rd_data` on the first pop after the fault. A wrong level count shows on `level`, `full` or `empty` in the cycle after the access.

// File: rtl/ptf_pkg.sv
package ptf_pkg;
    localparam int DATA_W  = 8;
    localparam int ENTRY_W = DATA_W + 2;

    typedef struct packed {
        logic              abort;
        logic              eop;
        logic [DATA_W-1:0] data;
    } ptf_entry_t;
endpackage

// File: rtl/ptf_tag_ctrl.sv
// Pending markers and packet length counter; resolves the marker pair for each byte.
module ptf_tag_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_eop,
    input  logic             ctl_abort,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_len,
    input  logic             cnt_cycle,
    input  logic             accept,
    output logic             tag_eop,
    output logic             tag_abort,
    output logic             pend_eop,
    output logic             pend_abort
);
    typedef struct packed {
        logic             eop;
        logic             abt;
        logic             cyc;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rel;
    } tag_st_t;

    tag_st_t st_d, st_q;
    logic    last_byte;

    always_comb begin
        last_byte = (st_q.cnt == CNT_W'(1));
        st_d      = st_q;
        // accepted byte consumes the pending markers and advances the length
        if (accept) begin
            st_d.eop = 1'b0;
            st_d.abt = 1'b0;
            if (last_byte) begin
                st_d.cnt = st_q.cyc ? st_q.rel : '0;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        // a control write wins over the self-clear of the same cycle
        if (ctl_wr) begin
            st_d.eop = ctl_eop;
            st_d.abt = ctl_abort;
        end
        if (cnt_wr) begin
            st_d.cnt = cnt_len;
            st_d.rel = cnt_len;
            st_d.cyc = cnt_cycle;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // abort outranks any end-of-packet request
    assign tag_abort  = st_q.abt;
    assign tag_eop    = (st_q.eop | last_byte) & ~st_q.abt;
    assign pend_eop   = st_q.eop;
    assign pend_abort = st_q.abt;
endmodule

// File: rtl/ptf_fifo.sv
// Circular queue with show-ahead head and a sticky drop flag.
module ptf_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 10,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level,
    output logic             ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [LVL_W-1:0] lvl;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t     st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         is_full, is_empty, wr_en, rd_en;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        is_full  = (st_q.lvl == LVL_W'(DEPTH));
        is_empty = (st_q.lvl == '0);
        wr_en    = push & ~is_full;
        rd_en    = pop & ~is_empty;
        st_d     = st_q;
        if (wr_en) st_d.wp = step_ptr(st_q.wp);
        if (rd_en) st_d.rp = step_ptr(st_q.rp);
        if (wr_en && !rd_en)      st_d.lvl = st_q.lvl + LVL_W'(1);
        else if (rd_en && !wr_en) st_d.lvl = st_q.lvl - LVL_W'(1);
        if (push && is_full) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[st_q.wp] <= wdata;
    end

    assign rdata = mem_q[st_q.rp];
    assign full  = is_full;
    assign empty = is_empty;
    assign level = st_q.lvl;
    assign ovf   = st_q.ovf;
endmodule

// File: rtl/ptf_wr_front.sv
module ptf_wr_front #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_wr,
    input  logic                      ctl_eop,
    input  logic                      ctl_abort,
    input  logic                      cnt_wr,
    input  logic [CNT_W-1:0]          cnt_len,
    input  logic                      cnt_cycle,
    input  logic                      dat_wr,
    input  logic [ptf_pkg::DATA_W-1:0] dat_wdata,
    input  logic                      pop,
    output logic [ptf_pkg::DATA_W-1:0] rd_data,
    output logic                      rd_eop,
    output logic                      rd_abort,
    output logic                      full,
    output logic                      empty,
    output logic [LVL_W-1:0]          level,
    output logic                      overflow
);
    import ptf_pkg::*;

    ptf_entry_t wr_entry, rd_entry;
    logic       accept, tag_eop, tag_abort, pend_eop, pend_abort;
    logic [ENTRY_W-1:0] rd_raw;

    assign accept = dat_wr & ~full;

    ptf_tag_ctrl #(.CNT_W(CNT_W)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_eop   (ctl_eop),
        .ctl_abort (ctl_abort),
        .cnt_wr    (cnt_wr),
        .cnt_len   (cnt_len),
        .cnt_cycle (cnt_cycle),
        .accept    (accept),
        .tag_eop   (tag_eop),
        .tag_abort (tag_abort),
        .pend_eop  (pend_eop),
        .pend_abort(pend_abort)
    );

    always_comb begin
        wr_entry.abort = tag_abort;
        wr_entry.eop   = tag_eop;
        wr_entry.data  = dat_wdata;
    end

    ptf_fifo #(.DEPTH(DEPTH), .W(ENTRY_W), .LVL_W(LVL_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dat_wr),
        .wdata (wr_entry),
        .pop   (pop),
        .rdata (rd_raw),
        .full  (full),
        .empty (empty),
        .level (level),
        .ovf   (overflow)
    );

    assign rd_entry = ptf_entry_t'(rd_raw);
    assign rd_data  = rd_entry.data;
    assign rd_eop   = rd_entry.eop;
    assign rd_abort = rd_entry.abort;
endmodule

// File: rtl/ptf_checker.sv
module ptf_checker #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             dat_wr,
    input logic             pop,
    input logic             full,
    input logic             empty,
    input logic [LVL_W-1:0] level,
    input logic             overflow,
    input logic             rd_eop,
    input logic             rd_abort,
    input logic             pend_eop,
    input logic             pend_abort
);
    AST_FULL_DROP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && full && !pop) |=> (level == $past(level)));              // R7
    AST_FULL_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && full) |=> overflow);                                     // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                             // R7
    AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |-> !(rd_eop && rd_abort));                                  // R6
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !full && !ctl_wr) |=> (!pend_eop && !pend_abort));       // R3
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));                                            // R8
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !dat_wr) |=> empty);                               // R8
    AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && pop && !full && !empty) |=> $stable(level));             // R8
endmodule

bind ptf_wr_front ptf_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .dat_wr    (dat_wr),
    .pop       (pop),
    .full      (full),
    .empty     (empty),
    .level     (level),
    .overflow  (overflow),
    .rd_eop    (rd_eop),
    .rd_abort  (rd_abort),
    .pend_eop  (pend_eop),
    .pend_abort(pend_abort)
);

// File: tb/tb_ptf_wr_front.sv
`timescale 1ns/1ps
module tb_ptf_wr_front;
    localparam int DEPTH = 16;
    localparam int CNT_W = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, ctl_eop = 0, ctl_abort = 0, cnt_wr = 0, cnt_cycle = 0;
    logic dat_wr = 0, pop = 0;
    logic [CNT_W-1:0] cnt_len = '0;
    logic [7:0] dat_wdata = '0;
    logic [7:0] rd_data;
    logic rd_eop, rd_abort, full, empty, overflow;
    logic [LVL_W-1:0] level;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model
    bit m_eop, m_abt, m_cyc, m_ovf;
    int m_cnt, m_rel;
    logic [9:0] mq[$];

    always #2 clk = ~clk;

    ptf_wr_front #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (.*);

    function automatic logic [9:0] exp_entry(input logic [7:0] d);
        bit e = m_eop || (m_cnt == 1);
        if (m_abt) return {1'b1, 1'b0, d};
        return {1'b0, e, d};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(level == LVL_W'(mq.size()), "R8", {req, " level"}, level, mq.size());
        chk(empty == (mq.size() == 0), "R8", {req, " empty"}, empty, mq.size() == 0);
        chk(full == (mq.size() == DEPTH), "R8", {req, " full"}, full, mq.size() == DEPTH);
        chk(overflow == m_ovf, "R7", {req, " overflow"}, overflow, m_ovf);
        if (mq.size() != 0)
            chk({rd_abort, rd_eop, rd_data} == mq[0], req, "head entry",
                {rd_abort, rd_eop, rd_data}, mq[0]);
    endtask

    task automatic step(input bit cw, input bit ce, input bit ca, input bit nw,
                        input int nl, input bit nc, input bit dw, input logic [7:0] dd,
                        input bit pp, input string req);
        bit was_full, can_pop;
        logic [9:0] ent;
        ctl_wr = cw; ctl_eop = ce; ctl_abort = ca;
        cnt_wr = nw; cnt_len = CNT_W'(nl); cnt_cycle = nc;
        dat_wr = dw; dat_wdata = dd; pop = pp;
        @(posedge clk);
        was_full = (mq.size() == DEPTH);
        can_pop  = pp && (mq.size() != 0);
        ent      = exp_entry(dd);
        if (can_pop) void'(mq.pop_front());
        if (dw && was_full) m_ovf = 1;
        if (dw && !was_full) begin
            mq.push_back(ent);
            m_eop = 0; m_abt = 0;
            if (m_cnt == 1) m_cnt = m_cyc ? m_rel : 0;
            else if (m_cnt != 0) m_cnt--;
        end
        if (cw) begin m_eop = ce; m_abt = ca; end
        if (nw) begin m_cnt = nl; m_rel = nl; m_cyc = nc; end
        @(negedge clk);
        ctl_wr = 0; cnt_wr = 0; dat_wr = 0; pop = 0;
        compare(req);
    endtask

    task automatic wr(input logic [7:0] d, input string req);
        step(0, 0, 0, 0, 0, 0, 1, d, 0, req);
    endtask
    task automatic rd(input string req);
        step(0, 0, 0, 0, 0, 0, 0, 8'h00, 1, req);
    endtask
    task automatic drain(input string req);
        while (mq.size() != 0) rd(req);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd5150);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(empty == 1'b1, "R9", "empty", empty, 1);
        chk(level == '0, "R9", "level", level, 0);
        chk(overflow == 1'b0, "R9", "overflow", overflow, 0);
        chk(full == 1'b0, "R9", "full", full, 0);

        // R2 pending marker copied, R3 cleared afterwards
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
        wr(8'hAA, "R2");
        chk({rd_abort, rd_eop, rd_data} == 10'h1AA, "R2", "marked byte", {rd_abort, rd_eop, rd_data}, 10'h1AA);
        wr(8'h03, "R3");
        rd("R3");
        chk({rd_abort, rd_eop, rd_data} == 10'h003, "R3", "byte after clear", {rd_abort, rd_eop, rd_data}, 10'h003);
        // R3 control write in the same cycle as a data write
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 0, 1, 0, 0, 0, 1, 8'h11, 0, "R3");
        wr(8'h22, "R3");
        drain("R3");

        // R4 length 3 without repeat: markers 0,0,1 then none (R5 non-repeat)
        step(0, 0, 0, 1, 3, 0, 0, 0, 0, "R4");
        for (int i = 0; i < 5; i++) wr(8'(8'h40 + i), "R4");
        rd("R4"); rd("R4");
        chk(rd_eop == 1'b1 && rd_data == 8'h42, "R4", "third byte marker", {rd_eop, rd_data}, 9'h142);
        drain("R4");

        // R5 length 2 with repeat
        step(0, 0, 0, 1, 2, 1, 0, 0, 0, "R5");
        for (int i = 0; i < 6; i++) wr(8'(8'h50 + i), "R5");
        rd("R5");
        chk(rd_eop == 1'b1 && rd_data == 8'h51, "R5", "first packet end", {rd_eop, rd_data}, 9'h151);
        drain("R5");
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R4");

        // R6 abort priority, also against the length marker
        step(1, 1, 1, 0, 0, 0, 0, 0, 0, "R6");
        wr(8'h66, "R6");
        chk(rd_abort == 1'b1 && rd_eop == 1'b0, "R6", "abort over eop", {rd_abort, rd_eop}, 2'b10);
        step(0, 0, 0, 1, 1, 0, 0, 0, 0, "R6");
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, "R6");
        wr(8'h67, "R6");
        wr(8'h68, "R6");
        drain("R6");

        // R8 pop on empty, push with pop
        rd("R8");
        wr(8'h70, "R8");
        step(0, 0, 0, 0, 0, 0, 1, 8'h71, 1, "R8");
        drain("R8");

        // R7 fill, drop a write with a marker pending, then recover
        for (int i = 0; i < DEPTH; i++) wr(8'(i), "R7");
        step(1, 1, 0, 1, 2, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        wr(8'hEE, "R7");
        chk(overflow == 1'b1 && level == LVL_W'(DEPTH), "R7", "drop on full", {overflow, level}, {1'b1, LVL_W'(DEPTH)});
        step(0, 0, 0, 0, 0, 0, 1, 8'hEF, 1, "R7");
        rd("R7");
        wr(8'hF0, "R7");
        drain("R7");
        chk(overflow == 1'b1, "R7", "overflow sticky", overflow, 1);

        // R1 random traffic checked entry by entry
        for (int n = 0; n < 4000; n++) begin
            bit cw, nw, dw, pp;
            cw = ($urandom % 10) == 0;
            nw = ($urandom % 40) == 0;
            dw = ($urandom % 2) == 0;
            pp = ($urandom % 5) < 2;
            step(cw, 1'($urandom), ($urandom % 4) == 0, nw, int'($urandom % 6),
                 1'($urandom), dw, 8'($urandom), pp, "R1");
        end
        drain("R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule